// File: doc/BRIEF.md
# CAN mailbox receive interrupt controller

This block tracks receive-pending state for a bank of message mailboxes and turns it into two interrupt lines. Each mailbox has an enable bit, a direction bit, an interrupt mask bit and a line-select bit, all held in registers reachable through a simple write/read port. When the bus engine reports that a mailbox has completed a reception, the block latches a pending bit for that mailbox. It then raises the interrupt line the mailbox is routed to, provided the mailbox is unmasked and that line is enabled.

Each line has a read-only flag register. It reports the number of the highest-numbered mailbox requesting on that line, whether any mailbox requests on it, and whether the global overwrite flag is steered to it. Software clears pending and overwrite bits by writing ones. A small identifier store sits beside the mailbox registers and accepts a write to a mailbox's identifier only while that mailbox is disabled.

Register map (6-bit word address): 0 enable, 1 direction (1 = receive), 2 mask (1 = interrupt allowed), 3 line select (0 = line 0, 1 = line 1), 4 pending (write 1 to clear), 5 overwrite (write 1 to clear), 6 control (bit 0 line-0 enable, bit 1 line-1 enable, bit 2 global-level), 7 line-0 flag, 8 line-1 flag, 32 to 63 identifier of mailbox (address − 32). Flag layout: bits [4:0] mailbox number, bit 8 mailbox request present, bit 9 global overwrite flag. Reads return data one clock after the address is presented.

Top module: `can_rx_irq_ctrl`

## Requirements
- R1: A receive pulse sets a mailbox's pending bit (register 4) only when its enable bit (register 0) is 1 and its direction bit (register 1) is 1.
- R2: A receive on an active mailbox sets its pending bit one cycle later. Writing 1 to a pending bit clears it. A clearing write and a receive in the same cycle leave the bit set and do not count as an overwrite.
- R3: A mailbox whose mask bit (register 2) is 0 keeps its pending bit but drives no interrupt line, and it is not reported in any flag register.
- R4: A pending, unmasked mailbox drives line 0 when its line-select bit (register 3) is 0 and line 1 when it is 1.
- R5: A line output is 0 in the cycle after its enable bit (control bit 0 for line 0, bit 1 for line 1) is 0.
- R6: A line's flag register holds in bits [4:0] the number of the highest-numbered mailbox requesting on that line, with bit 8 set, and reads 0 when no mailbox requests.
- R7: When any overwrite bit is set, bit 9 of the line-1 flag is set if control bit 2 is 1, and bit 9 of the line-0 flag otherwise. That line's output is then asserted if the line is enabled.
- R8: A write to an identifier address stores the value only if that mailbox's enable bit is 0. Otherwise the stored identifier is left unchanged.
- R9: A receive on an active mailbox whose pending bit is already set is dropped and sets that mailbox's sticky overwrite bit (register 5), which stays set until a 1 is written to it.
- R10: A line output stays asserted while any enabled, unmasked mailbox routed to it still has its pending bit set.
- R11: After reset every register reads 0 and both line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | NMB | Per-mailbox receive-complete pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq_line0 | output | 1 | Interrupt line 0 |
| irq_line1 | output | 1 | Interrupt line 1 |

## Verification
The hardest situation to reach from the ports is a receive landing in the same cycle as the software write that clears the same pending bit. In that race the bit must stay set and must not be counted as an overwrite. The bench reaches it by driving the write strobe and the receive pulse in the same half-cycle and then reading both the pending and the overwrite registers. A second case that needs deliberate setup is the global overwrite flag on its own: all masks are zeroed so that mailbox requests cannot mask the effect, and the global-level bit is then toggled to move the line.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int DW = 32;
  localparam logic [5:0] ADR_EN    = 6'd0;
  localparam logic [5:0] ADR_DIR   = 6'd1;
  localparam logic [5:0] ADR_MASK  = 6'd2;
  localparam logic [5:0] ADR_LSEL  = 6'd3;
  localparam logic [5:0] ADR_PEND  = 6'd4;
  localparam logic [5:0] ADR_OVW   = 6'd5;
  localparam logic [5:0] ADR_CTRL  = 6'd6;
  localparam logic [5:0] ADR_FLAG0 = 6'd7;
  localparam logic [5:0] ADR_FLAG1 = 6'd8;
  localparam int FLAG_ANY_BIT = 8;
  localparam int FLAG_GLB_BIT = 9;
endpackage

// File: rtl/can_rx_pend_bank.sv
module can_rx_pend_bank #(
  parameter int NMB = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NMB-1:0] rx,
  input  logic [NMB-1:0] act,
  input  logic [NMB-1:0] clr_pend,
  input  logic [NMB-1:0] clr_ovw,
  output logic [NMB-1:0] pend,
  output logic [NMB-1:0] ovw
);
  logic [NMB-1:0] rx_act;
  logic [NMB-1:0] take;
  logic [NMB-1:0] lost;

  assign rx_act = rx & act;
  // a clear in the same cycle frees the slot, so the new receive is taken
  assign take   = rx_act & (~pend | clr_pend);
  assign lost   = rx_act & pend & ~clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ovw  <= '0;
    end else begin
      pend <= (pend & ~clr_pend) | take;
      ovw  <= (ovw & ~clr_ovw) | lost;
    end
  end

  // R2
  pend_spur_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(rx_act)) == '0);

  // R2
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & $past(clr_pend) & ~$past(rx_act)) == '0);

  // R9
  ovw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ovw) & ~$past(clr_ovw) & ~ovw) == '0);

  // R9
  ovw_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ovw & ~$past(ovw) & ~$past(pend)) == '0);
endmodule

// File: rtl/can_prio_enc.sv
module can_prio_enc #(
  parameter int NMB = 32,
  parameter int IW  = $clog2(NMB)
) (
  input  logic [NMB-1:0] req,
  output logic [IW-1:0]  idx,
  output logic           any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < NMB; i++) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  // R6
  always_comb begin
    if (any) begin
      enc_top_chk: assert ((req >> idx) == NMB'(1));
    end
  end
endmodule

// File: rtl/can_irq_line.sv
module can_irq_line #(
  parameter int NMB = 32,
  parameter int IW  = $clog2(NMB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NMB-1:0] req,
  input  logic           line_en,
  input  logic           glb_sel,
  input  logic           glb_flag,
  output logic           irq,
  output logic [IW-1:0]  vec_q,
  output logic           any_q,
  output logic           glb_q
);
  logic [IW-1:0] vec;
  logic          any;

  can_prio_enc #(.NMB(NMB), .IW(IW)) u_enc (
    .req (req),
    .idx (vec),
    .any (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      vec_q <= '0;
      any_q <= 1'b0;
      glb_q <= 1'b0;
    end else begin
      irq   <= line_en & (any | (glb_sel & glb_flag));
      vec_q <= vec;
      any_q <= any;
      glb_q <= glb_sel & glb_flag;
    end
  end

  // R5
  line_off_chk: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> !irq);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_en && (req != '0)) |=> irq);

  // R6
  vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !any_q |-> (vec_q == '0));
endmodule

// File: rtl/can_id_ram.sv
module can_id_ram #(
  parameter int DEPTH = 32,
  parameter int IDW   = 29,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [IDW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [IDW-1:0] rdata
);
  logic [IDW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_rx_irq_ctrl.sv
module can_rx_irq_ctrl #(
  parameter int NMB = 32,
  parameter int IDW = 29,
  parameter int AW  = $clog2(NMB) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NMB-1:0] rx_done,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq_line0,
  output logic           irq_line1
);
  import can_irq_pkg::*;

  localparam int IW = $clog2(NMB);

  logic [NMB-1:0] mb_en, mb_dir, mb_mask, mb_lsel;
  logic [2:0]     ctrl;
  logic [NMB-1:0] pend, ovw, act;
  logic [NMB-1:0] clr_pend, clr_ovw;
  logic           glb_flag;
  logic [1:0]     irq;
  logic [IW-1:0]  vec_q [2];
  logic [1:0]     any_q, glb_q;
  logic [DW-1:0]  flag_w [2];
  logic [DW-1:0]  csr_q;
  logic [IDW-1:0] id_q;
  logic           sel_id_q;
  logic           id_region;
  logic           id_we;

  assign id_region = reg_addr[AW-1];
  assign act       = mb_en & mb_dir;
  assign clr_pend  = (reg_we && reg_addr == ADR_PEND[AW-1:0]) ? reg_wdata[NMB-1:0] : '0;
  assign clr_ovw   = (reg_we && reg_addr == ADR_OVW[AW-1:0])  ? reg_wdata[NMB-1:0] : '0;
  assign glb_flag  = |ovw;
  assign id_we     = reg_we & id_region & ~mb_en[reg_addr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      mb_en   <= '0;
      mb_dir  <= '0;
      mb_mask <= '0;
      mb_lsel <= '0;
      ctrl    <= '0;
    end else if (reg_we && !id_region) begin
      case (reg_addr)
        ADR_EN[AW-1:0]:   mb_en   <= reg_wdata[NMB-1:0];
        ADR_DIR[AW-1:0]:  mb_dir  <= reg_wdata[NMB-1:0];
        ADR_MASK[AW-1:0]: mb_mask <= reg_wdata[NMB-1:0];
        ADR_LSEL[AW-1:0]: mb_lsel <= reg_wdata[NMB-1:0];
        ADR_CTRL[AW-1:0]: ctrl    <= reg_wdata[2:0];
        default: ;
      endcase
    end
  end

  can_rx_pend_bank #(.NMB(NMB)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .rx       (rx_done),
    .act      (act),
    .clr_pend (clr_pend),
    .clr_ovw  (clr_ovw),
    .pend     (pend),
    .ovw      (ovw)
  );

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NMB-1:0] route;
    logic [NMB-1:0] req;
    assign route = (l == 1) ? mb_lsel : ~mb_lsel;
    assign req   = pend & mb_mask & act & route;

    can_irq_line #(.NMB(NMB), .IW(IW)) u_line (
      .clk      (clk),
      .rst      (rst),
      .req      (req),
      .line_en  (ctrl[l]),
      .glb_sel  ((l == 1) ? ctrl[2] : ~ctrl[2]),
      .glb_flag (glb_flag),
      .irq      (irq[l]),
      .vec_q    (vec_q[l]),
      .any_q    (any_q[l]),
      .glb_q    (glb_q[l])
    );

    always_comb begin
      flag_w[l]               = '0;
      flag_w[l][IW-1:0]       = vec_q[l];
      flag_w[l][FLAG_ANY_BIT] = any_q[l];
      flag_w[l][FLAG_GLB_BIT] = glb_q[l];
    end
  end

  assign irq_line0 = irq[0];
  assign irq_line1 = irq[1];

  can_id_ram #(.DEPTH(NMB), .IDW(IDW), .AW(IW)) u_ids (
    .clk   (clk),
    .we    (id_we),
    .waddr (reg_addr[IW-1:0]),
    .wdata (reg_wdata[IDW-1:0]),
    .raddr (reg_addr[IW-1:0]),
    .rdata (id_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q    <= '0;
      sel_id_q <= 1'b0;
    end else begin
      sel_id_q <= id_region;
      case (reg_addr)
        ADR_EN[AW-1:0]:    csr_q <= DW'(mb_en);
        ADR_DIR[AW-1:0]:   csr_q <= DW'(mb_dir);
        ADR_MASK[AW-1:0]:  csr_q <= DW'(mb_mask);
        ADR_LSEL[AW-1:0]:  csr_q <= DW'(mb_lsel);
        ADR_PEND[AW-1:0]:  csr_q <= DW'(pend);
        ADR_OVW[AW-1:0]:   csr_q <= DW'(ovw);
        ADR_CTRL[AW-1:0]:  csr_q <= DW'(ctrl);
        ADR_FLAG0[AW-1:0]: csr_q <= flag_w[0];
        ADR_FLAG1[AW-1:0]: csr_q <= flag_w[1];
        default:           csr_q <= '0;
      endcase
    end
  end

  assign reg_rdata = sel_id_q ? DW'(id_q) : csr_q;

  // R1
  inactive_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(act)) == '0);

  // R7
  glb_route_chk: assert property (@(posedge clk) disable iff (rst)
    !(glb_q[0] && glb_q[1]));
endmodule

// File: tb/can_rx_irq_ctrl_bench.sv
module can_rx_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rx_done = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_line0, irq_line1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_irq_ctrl u_can_rx_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rx_done   (rx_done),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_line0 (irq_line0),
    .irq_line1 (irq_line1)
  );

  typedef struct packed {
    logic [4:0] mb;
    logic       lsel;
    logic       msk;
    logic       en0;
    logic       en1;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{5'd3,  1'b0, 1'b1, 1'b1, 1'b1},
    '{5'd17, 1'b1, 1'b1, 1'b1, 1'b1},
    '{5'd9,  1'b0, 1'b0, 1'b1, 1'b1},
    '{5'd31, 1'b1, 1'b1, 1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd22, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    rx_done = m;
    @(negedge clk);
    rx_done = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] fexp;
    logic [31:0] bit_m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R11: reset state
    for (int a = 0; a < 9; a++) begin
      rd(6'(a), d);
      chk("R11 register after reset", d, 32'd0);
    end
    chk("R11 line0 after reset", {31'd0, irq_line0}, 32'd0);
    chk("R11 line1 after reset", {31'd0, irq_line1}, 32'd0);

    // table walk: R3 R4 R5 R6
    for (int k = 0; k < 6; k++) begin
      bit_m = 32'd1 << TBL[k].mb;
      wr(6'd0, 32'hFFFF_FFFF);
      wr(6'd1, 32'hFFFF_FFFF);
      wr(6'd2, TBL[k].msk ? bit_m : 32'd0);
      wr(6'd3, TBL[k].lsel ? bit_m : 32'd0);
      wr(6'd6, {29'd0, 1'b0, TBL[k].en1, TBL[k].en0});
      pulse(bit_m);
      settle();
      chk("R4 line0 routing", {31'd0, irq_line0},
          {31'd0, TBL[k].msk & ~TBL[k].lsel & TBL[k].en0});
      chk("R4 line1 routing", {31'd0, irq_line1},
          {31'd0, TBL[k].msk & TBL[k].lsel & TBL[k].en1});
      rd(6'd4, d);
      chk("R3 pending kept", d, bit_m);
      fexp = TBL[k].msk ? (32'h100 | {27'd0, TBL[k].mb}) : 32'd0;
      rd(6'd7, d);
      chk("R6 flag0 vector", d, TBL[k].lsel ? 32'd0 : fexp);
      rd(6'd8, d);
      chk("R6 flag1 vector", d, TBL[k].lsel ? fexp : 32'd0);
      wr(6'd4, bit_m);
      settle();
      chk("R2 cleared line0", {31'd0, irq_line0}, 32'd0);
      chk("R2 cleared line1", {31'd0, irq_line1}, 32'd0);
    end
    rd(6'd4, d);
    chk("R2 pending cleared by write 1", d, 32'd0);

    // R1: inactive mailboxes ignore receives
    wr(6'd0, 32'hFFFF_FFFF);
    wr(6'd1, ~(32'd1 << 5));
    pulse(32'd1 << 5);
    wr(6'd1, 32'hFFFF_FFFF);
    wr(6'd0, ~(32'd1 << 6));
    pulse(32'd1 << 6);
    rd(6'd4, d);
    chk("R1 transmit or disabled mailbox ignored", d, 32'd0);
    wr(6'd0, 32'hFFFF_FFFF);

    // R6 R10: two pending on line 0
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd3, 32'd0);
    wr(6'd6, 32'd1);
    pulse((32'd1 << 4) | (32'd1 << 12));
    settle();
    rd(6'd7, d);
    chk("R6 highest of two", d, 32'h100 | 32'd12);
    wr(6'd4, 32'd1 << 12);
    settle();
    chk("R10 line held with one left", {31'd0, irq_line0}, 32'd1);
    rd(6'd7, d);
    chk("R6 vector moves to remaining", d, 32'h100 | 32'd4);
    wr(6'd4, 32'd1 << 4);
    settle();
    chk("R10 line released", {31'd0, irq_line0}, 32'd0);
    rd(6'd7, d);
    chk("R6 flag empty", d, 32'd0);

    // R2: clear and receive in the same cycle
    pulse(32'd1 << 7);
    reg_we = 1'b1; reg_addr = 6'd4; reg_wdata = 32'd1 << 7; rx_done = 32'd1 << 7;
    @(negedge clk);
    reg_we = 1'b0; rx_done = '0;
    rd(6'd4, d);
    chk("R2 same-cycle receive wins", d, 32'd1 << 7);
    rd(6'd5, d);
    chk("R2 same-cycle no overwrite", d, 32'd0);
    wr(6'd4, 32'd1 << 7);

    // R9 R7: overwrite and global flag routing
    wr(6'd2, 32'd0);
    pulse(32'd1 << 10);
    pulse(32'd1 << 10);
    rd(6'd5, d);
    chk("R9 overwrite sticky set", d, 32'd1 << 10);
    rd(6'd4, d);
    chk("R9 pending still set", d, 32'd1 << 10);
    wr(6'd6, 32'b110);
    settle();
    chk("R7 line1 global", {31'd0, irq_line1}, 32'd1);
    chk("R7 line0 quiet", {31'd0, irq_line0}, 32'd0);
    rd(6'd8, d);
    chk("R7 flag1 global bit", d, 32'h200);
    rd(6'd7, d);
    chk("R7 flag0 no global", d, 32'd0);
    wr(6'd6, 32'b001);
    settle();
    chk("R7 line0 global", {31'd0, irq_line0}, 32'd1);
    rd(6'd7, d);
    chk("R7 flag0 global bit", d, 32'h200);
    rd(6'd5, d);
    chk("R9 overwrite still set", d, 32'd1 << 10);
    wr(6'd5, 32'd1 << 10);
    settle();
    rd(6'd5, d);
    chk("R9 overwrite cleared", d, 32'd0);
    chk("R7 line0 drops", {31'd0, irq_line0}, 32'd0);
    wr(6'd4, 32'd1 << 10);

    // R8: identifier writes gated by enable
    wr(6'd0, ~((32'd1 << 2) | (32'd1 << 3)));
    wr(6'd34, 32'h0000_0123);
    wr(6'd35, 32'h0000_0055);
    wr(6'd0, ~(32'd1 << 2));
    wr(6'd35, 32'h0000_0456);
    rd(6'd34, d);
    chk("R8 write while disabled stored", d, 32'h0000_0123);
    rd(6'd35, d);
    chk("R8 write while enabled ignored", d, 32'h0000_0055);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule